// File: doc/BRIEF.md
# DMA Transfer Count and Request Controller

This block does the slave-side bookkeeping for DMA transfers into a graphics controller's host bus interface. Software programs two registers through a simple register port. One holds the number of data units to move. The other is a three-bit setup word that chooses the unit size and how the DMA request line behaves. A start pulse copies the programmed count into an internal down-counter. A per-word acceptance strobe from the data path then consumes that count. The block raises `busy` for the length of the transfer and drives `dreq` toward the external DMA controller. On completion it emits a one-cycle `done`.

The count field is `CNT_W` bits wide (24 by default). A programmed value of zero stands for the largest transfer, 2^`CNT_W` units. A unit is either a single 32-bit word or a burst of `BURST_WORDS` words (eight by default). When request gating is selected, `dreq` follows the receive buffer's `rx_ready` flag. The count register cannot be rewritten while a transfer runs. The setup word is sampled at start and held for the whole transfer.

Top module: `dmac_xfer_ctrl`

## Requirements
- R1: After reset, `busy`, `dreq` and `done` are 0, and both registers read back as 0.
- R2: A write to byte offset 0x00 while idle stores `reg_wdata[CNT_W-1:0]` as the count. Reading offset 0x00 returns that value in bits `CNT_W-1:0`, and the bits above read 0.
- R3: A write to offset 0x04 stores `reg_wdata[2:0]` as the setup word. Bit 0 is the eight-word unit select, bit 1 is request gating, and bit 2 is single-address mode. Reading 0x04 returns those bits with all higher bits 0. Any other offset reads 0 and ignores writes.
- R4: While `busy` is 1, writes to offset 0x00 are ignored, and a later read returns the value held before the transfer.
- R5: A `start` pulse while idle sets `busy` on the next cycle. In single-word mode (setup bit 0 = 0), a transfer of count N ends on the clock edge of the N-th accepted `word_ack`.
- R6: A count of 0 starts a transfer of 2^`CNT_W` units.
- R7: With setup bit 0 = 1 at start, a unit is consumed only after `BURST_WORDS` accepted words, so count N ends after N*`BURST_WORDS` acks.
- R8: With setup bits 1 and 2 both 0 at start, `dreq` equals `busy` regardless of `rx_ready`.
- R9: With setup bit 1 = 1 at start, `dreq` is `busy` AND `rx_ready`.
- R10: With setup bit 2 = 1 at start, `dreq` is gated by `rx_ready` exactly as in R9, whatever bit 1 holds.
- R11: `done` is high for exactly one cycle, the first cycle with `busy` low after a transfer, and `dreq` is 0 in that cycle.
- R12: A `start` pulse while `busy` is 1 is ignored and does not change the remaining count.
- R13: `word_ack` while idle is ignored and does not reduce the next transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| start | input | 1 | Begin a transfer (ignored while busy) |
| word_ack | input | 1 | One 32-bit word accepted by the data path |
| rx_ready | input | 1 | Receive buffer can accept a word at once |
| dreq | output | 1 | DMA request toward the external controller |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `CNT_W` = 6 and the default `BURST_WORDS` = 8. With that width the zero-means-maximum case becomes 64 units, which a short run can exhaust in full. It also makes the discarded upper write-data bits a wide field that is easy to probe. The eight-word unit mode is exercised at its default depth, so the phase counter's wrap at the burst boundary is covered.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned OFS_COUNT = 'h00;
    localparam int unsigned OFS_SETUP = 'h04;

    // Bit order fixes the software-visible positions: [2] [1] [0]
    typedef struct packed {
        logic single_addr;
        logic gate_req;
        logic wide_unit;
    } setup_t;

    localparam int unsigned SETUP_W = $bits(setup_t);

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic                lock,
    output logic [REG_W-1:0]    rdata,
    output logic [CNT_W-1:0]    count,
    output setup_t              setup
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        setup_t           setup;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_count, hit_setup;
    logic unused_wdata;

    assign hit_count = (addr == ADDR_W'(OFS_COUNT));
    assign hit_setup = (addr == ADDR_W'(OFS_SETUP));

    generate
        if (CNT_W < REG_W) begin : g_pad
            assign unused_wdata = ^wdata[REG_W-1:CNT_W];
        end else begin : g_full
            assign unused_wdata = 1'b0;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (wr && hit_count && !lock) begin
            r_d.count = wdata[CNT_W-1:0];
        end
        if (wr && hit_setup) begin
            r_d.setup = setup_t'(wdata[SETUP_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_count) begin
            rdata = REG_W'(r_q.count);
        end else if (hit_setup) begin
            rdata = {{(REG_W-SETUP_W){1'b0}}, r_q.setup};
        end
    end

    assign count = r_q.count;
    assign setup = r_q.setup;

    // R4: a locked count register keeps its value across a write
    p_count_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr && hit_count) |=> (r_q.count == $past(r_q.count)));

    // R3: setup readback never carries bits above the control field
    p_setup_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_setup |-> (rdata[REG_W-1:SETUP_W] == '0));

endmodule

// File: rtl/dmac_counter.sv
module dmac_counter
    import dmac_pkg::*;
#(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned BURST_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word_ack,
    input  logic [CNT_W-1:0] load_count,
    input  setup_t           setup,
    output logic             busy,
    output logic             done,
    output setup_t           mode
);

    localparam int unsigned REM_W = CNT_W + 1;
    localparam int unsigned PH_W  = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BURST_WORDS - 1);
    localparam logic [REM_W-1:0] REM_MAX = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic [PH_W-1:0]  phase;
        logic             busy;
        logic             done;
        setup_t           mode;
    } cnt_t;

    cnt_t s_d, s_q;
    logic unit_end;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unit_end = !s_q.mode.wide_unit || (s_q.phase == PH_LAST);
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.phase = '0;
                s_d.mode  = setup;
                s_d.rem   = (load_count == '0) ? REM_MAX : {1'b0, load_count};
            end
        end else if (word_ack) begin
            if (unit_end) begin
                s_d.phase = '0;
                s_d.rem   = s_q.rem - REM_W'(1);
                if (s_q.rem == REM_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end else begin
                s_d.phase = s_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign mode = s_q.mode;

    // R5: a running transfer always has work left
    p_rem_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.rem != '0));

    // R11: completion is a single-cycle pulse that follows a busy cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> (!s_q.busy && $past(s_q.busy)));

    // R12: a start during a transfer leaves the remaining count alone
    p_restart_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start && !word_ack) |=> (s_q.rem == $past(s_q.rem)));

    // R13: acks while idle do not begin or alter a transfer
    p_idle_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !start) |=> (!s_q.busy && s_q.rem == $past(s_q.rem)));

    // R7: the word phase only advances inside eight-word units
    p_phase_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.mode.wide_unit) |-> (s_q.phase == '0));

endmodule

// File: rtl/dmac_req.sv
module dmac_req (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic gate_req,
    input  logic single_addr,
    input  logic rx_ready,
    output logic dreq
);

    logic throttle;

    // Single-address mode always paces the request by receiver readiness
    assign throttle = gate_req || single_addr;
    assign dreq     = busy && (!throttle || rx_ready);

    // R8: without throttling the request tracks busy exactly
    p_free_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !gate_req && !single_addr) |-> dreq);

    // R9 / R10: a throttled request drops while the receiver is not ready
    p_gated_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle && !rx_ready) |-> !dreq);

endmodule

// File: rtl/dmac_xfer_ctrl.sv
module dmac_xfer_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned BURST_WORDS = 8,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              start,
    input  logic              word_ack,
    input  logic              rx_ready,
    output logic              dreq,
    output logic              busy,
    output logic              done
);

    logic [CNT_W-1:0] count_val;
    setup_t           setup_val;
    setup_t           mode_val;
    logic             busy_w;
    logic             done_w;
    logic             dreq_w;

    dmac_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .lock  (busy_w),
        .rdata (reg_rdata),
        .count (count_val),
        .setup (setup_val)
    );

    dmac_counter #(
        .CNT_W       (CNT_W),
        .BURST_WORDS (BURST_WORDS)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_ack   (word_ack),
        .load_count (count_val),
        .setup      (setup_val),
        .busy       (busy_w),
        .done       (done_w),
        .mode       (mode_val)
    );

    dmac_req u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy_w),
        .gate_req    (mode_val.gate_req),
        .single_addr (mode_val.single_addr),
        .rx_ready    (rx_ready),
        .dreq        (dreq_w)
    );

    assign busy = busy_w;
    assign done = done_w;
    assign dreq = dreq_w;

    // R11: the request is withdrawn in the completion cycle
    p_no_req_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dreq);

    // R1: nothing is requested while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dreq);

endmodule

// File: tb/test_dmac_xfer_ctrl.sv
`timescale 1ns/1ps
module test_dmac_xfer_ctrl;

    localparam int CNT_W  = 6;
    localparam int BURST  = 8;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              start = 1'b0;
    logic              word_ack = 1'b0;
    logic              rx_ready = 1'b1;
    logic              dreq, busy, done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    int m_cnt = 0, m_setup = 0, m_mode = 0, m_words = 0;
    bit m_busy = 0, m_done = 0;

    always #2 clk = ~clk;

    dmac_xfer_ctrl #(
        .CNT_W (CNT_W), .BURST_WORDS (BURST), .ADDR_W (ADDR_W)
    ) i_dmac_xfer_ctrl (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .start (start),
        .word_ack (word_ack), .rx_ready (rx_ready), .dreq (dreq),
        .busy (busy), .done (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model advances on each edge, then every output is compared 1 ns later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_setup = 0; m_mode = 0; m_words = 0; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (word_ack) begin
                    m_words--;
                    if (m_words == 0) begin m_busy = 0; m_done = 1; end
                end
            end else if (start) begin
                m_busy  = 1;
                m_mode  = m_setup;
                m_words = ((m_cnt == 0) ? (1 << CNT_W) : m_cnt) * (((m_setup & 1) != 0) ? BURST : 1);
            end
            if (reg_wr && reg_addr == 8'h00 && !(m_busy && !m_done && !start) && !$past(busy)) begin
                m_cnt = int'(reg_wdata) & ((1 << CNT_W) - 1);
            end
            if (reg_wr && reg_addr == 8'h04) m_setup = int'(reg_wdata) & 7;
        end
        #1;
        if (rst_n) begin
            int exp_rd;
            bit exp_dreq;
            string dlab;
            exp_rd = (reg_addr == 8'h00) ? m_cnt : (reg_addr == 8'h04) ? m_setup : 0;
            exp_dreq = m_busy && (((m_mode & 6) == 0) || rx_ready);
            dlab = ((m_mode & 4) != 0) ? "R10" : ((m_mode & 2) != 0) ? "R9" : "R8";
            check(busy == m_busy, "R5 busy", busy, m_busy);
            check(done == m_done, "R11 done", done, m_done);
            check(dreq == exp_dreq, dlab, dreq, exp_dreq);
            check(reg_rdata == 32'(exp_rd), (reg_addr == 0) ? "R2 rdata" : "R3 rdata", reg_rdata, exp_rd);
        end
    end

    task automatic wr_reg(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = ADDR_W'(a); reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic acks(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); word_ack = 1'b1;
            @(negedge clk); word_ack = 1'b0;
            if (gap && (i % 3 == 1)) @(negedge clk);
        end
    endtask

    task automatic read_check(input int a, input int exp, input string req);
        @(negedge clk); reg_addr = ADDR_W'(a);
        #1 check(reg_rdata == 32'(exp), req, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        check(busy == 0 && dreq == 0 && done == 0, "R1 flags", {busy, dreq, done}, 0);
        read_check(0, 0, "R1 count");
        read_check(4, 0, "R1 setup");

        // R2: count field, upper bits discarded
        wr_reg(0, 32'hFF00_0005);
        read_check(0, 5, "R2 masked");
        // R3: setup field and unmapped offset
        wr_reg(4, 32'hFFFF_FFFD);
        read_check(4, 5, "R3 setup");
        wr_reg(8, 32'hFFFF_FFFF);
        read_check(8, 0, "R3 unmapped");
        wr_reg(4, 32'h0);

        // R5 / R8: single-word transfer of 3, receiver toggling
        wr_reg(0, 3);
        pulse_start();
        #1 check(busy == 1, "R5 started", busy, 1);
        @(negedge clk); rx_ready = 1'b0;
        #1 check(dreq == 1, "R8 ungated", dreq, 1);
        rx_ready = 1'b1;
        // R4: write while busy ignored
        wr_reg(0, 9);
        read_check(0, 3, "R4 locked");
        // R12: restart mid-transfer ignored
        acks(1, 0);
        pulse_start();
        acks(1, 0);
        #1 check(busy == 1, "R12 still busy", busy, 1);
        acks(1, 0);
        #1 check(busy == 0, "R12 ended at original count", busy, 0);

        // R13: idle acks ignored
        acks(4, 0);
        wr_reg(0, 2);
        pulse_start();
        acks(1, 1);
        #1 check(busy == 1, "R13 count intact", busy, 1);
        acks(1, 0);
        #1 check(busy == 0, "R13 end", busy, 0);

        // R9: gated request
        wr_reg(4, 2);
        wr_reg(0, 4);
        pulse_start();
        @(negedge clk); rx_ready = 1'b0;
        #1 check(dreq == 0, "R9 gated low", dreq, 0);
        rx_ready = 1'b1;
        #1 check(dreq == 1, "R9 gated high", dreq, 1);
        acks(4, 1);

        // R10: single-address mode throttles with bit1 clear
        wr_reg(4, 4);
        pulse_start();
        @(negedge clk); rx_ready = 1'b0;
        #1 check(dreq == 0, "R10 throttled", dreq, 0);
        rx_ready = 1'b1;
        acks(4, 0);

        // R7: eight-word units, count 2
        wr_reg(4, 1);
        wr_reg(0, 2);
        pulse_start();
        acks(2 * BURST - 1, 1);
        #1 check(busy == 1, "R7 one word left", busy, 1);
        acks(1, 0);
        #1 check(busy == 0, "R7 finished", busy, 0);

        // R6: zero means 2^CNT_W units
        wr_reg(4, 0);
        wr_reg(0, 0);
        pulse_start();
        acks((1 << CNT_W) - 1, 0);
        #1 check(busy == 1, "R6 max not reached", busy, 1);
        acks(1, 0);
        #1 check(busy == 0, "R6 max reached", busy, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule